// File: doc/BRIEF.md
# Remote Fault Re-check Sequencer

This block runs on the management side of an Ethernet port. Once software has seen a far-end fault, reading the fault status again does not reliably show whether the fault is still there. On a start pulse, the block runs a short recovery sequence through a generic register-access port. First it writes the PHY control register to force 100 Mbps full duplex with internal loopback. It then waits a set number of timer ticks. Next it writes the control register again to force 100 Mbps full duplex with loopback off. Last, it reads the status register.

From the status word it derives two results: whether the far-end fault is still present and whether the link is down. It raises a one-cycle done pulse and holds both results until the next accepted start. Each register access holds its request until the access port returns done. Only one access is outstanding at a time. The serial management wire protocol and the PHY itself sit outside this block.

Top module: `rfault_recheck_seq`

## Requirements
- R1: A start pulse seen while idle begins the sequence, and `busy_o` goes high from the next cycle. The first access is a write to address 0 with data 0x6100 (forced 100 Mbps full duplex with loopback).
- R2: After the first write completes, the block counts exactly `WAIT_TICKS` cycles in which `tick_i` is high. Only then does it issue the second access.
- R3: The second access is a write to address 0 with data 0x2100 (forced 100 Mbps full duplex, loopback off).
- R4: After the second write completes, the block issues a read of address 1. At most one request is active at a time. A request, together with its address and write data, stays stable until the cycle in which `reg_done_i` is high. That request then drops at the following edge.
- R5: The result `fault_present_o` equals bit 4 of the returned status word. The result `link_down_o` equals the inverse of bit 2 of that word.
- R6: `done_o` is high for exactly one cycle, the cycle after the read's done. The results are valid from that cycle and hold until the next accepted start, which clears both to 0.
- R7: A start pulse that arrives while `busy_o` is high is ignored. It causes no extra access and does not restart the sequence.
- R8: In reset, and in the cycle after it, both requests, `busy_o`, `done_o` and both results are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Begin a re-check (pulse) |
| tick_i | input | 1 | Timer tick that paces the loopback wait |
| reg_wr_req_o | output | 1 | Register write request, held until done |
| reg_rd_req_o | output | 1 | Register read request, held until done |
| reg_addr_o | output | ADDR_W | Register address of the active request |
| reg_wdata_o | output | DATA_W | Write data of the active request |
| reg_rdata_i | input | DATA_W | Read data, valid while reg_done_i is high on a read |
| reg_done_i | input | 1 | Access completion, one cycle |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | Sequence finished (one-cycle pulse) |
| fault_present_o | output | 1 | Far-end fault still present |
| link_down_o | output | 1 | Link reported down |

## Verification
The assertions assume that the access port raises `reg_done_i` only while a request is pending. They also assume that `reg_done_i` lasts one cycle and that read data is valid in that same cycle. The bench's register responder keeps to this. It waits for a request at the falling edge, optionally delays, drives data and a single done cycle, then returns to polling.

The bench drives ticks as single-cycle pulses with a fixed spacing per run. It also covers the case where a tick is high on every cycle. Start is driven as a one-cycle pulse, both while idle and while the sequence is busy.

// File: rtl/rfr_pkg.sv
// Package: shared types for the remote fault re-check sequencer.
// Assumes: nothing beyond IEEE 1800-2017.
package rfr_pkg;

    // Sequencer states, in the order the sequence visits them.
    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_LOOP_WR = 3'd1,
        ST_WAIT    = 3'd2,
        ST_NORM_WR = 3'd3,
        ST_STAT_RD = 3'd4,
        ST_REPORT  = 3'd5
    } rfr_state_e;

    // True in states that own an access on the register port.
    function automatic logic state_needs_access(rfr_state_e s);
        return (s == ST_LOOP_WR) || (s == ST_NORM_WR) || (s == ST_STAT_RD);
    endfunction

endpackage

// File: rtl/rfr_wait_timer.sv
// Module: rfr_wait_timer
// Counts timer ticks while enabled. It asserts expired_o in the cycle of
// the WAIT_TICKS-th tick. Dropping run_i clears the count.
// Assumes: WAIT_TICKS >= 1; tick_i is synchronous to clk.
module rfr_wait_timer #(
    parameter int WAIT_TICKS = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    input  logic tick_i,
    output logic expired_o
);
    localparam int CNT_W = $clog2(WAIT_TICKS + 1);
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(WAIT_TICKS - 1);

    logic [CNT_W-1:0] cnt_q;

    // Tick counter, cleared whenever the wait is not running.
    always_ff @(posedge clk) begin
        if (!rst_n || !run_i) begin
            cnt_q <= '0;
        end else if (tick_i) begin
            cnt_q <= (cnt_q == LAST_CNT) ? '0 : cnt_q + 1'b1;
        end
    end

    // Expiry fires on the final tick of the window.
    always_comb begin
        expired_o = run_i && tick_i && (cnt_q == LAST_CNT);
    end

    // The count never passes the last tick of the window.
    assert_count_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST_CNT);

    // Outside the wait the count sits at zero.
    assert_idle_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> (cnt_q == '0) || run_i);

endmodule

// File: rtl/rfr_access_port.sv
// Module: rfr_access_port
// Turns a command from the sequencer into a held register request.
// The request is issued one edge after cmd_valid_i while the port is free.
// It holds until done_i and drops at that edge. ack_o marks the done cycle.
// Assumes: done_i comes only while a request is pending and lasts one cycle.
module rfr_access_port #(
    parameter int ADDR_W = 5,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid_i,
    input  logic              cmd_rd_i,
    input  logic [ADDR_W-1:0] cmd_addr_i,
    input  logic [DATA_W-1:0] cmd_data_i,
    input  logic              done_i,
    output logic              wr_req_o,
    output logic              rd_req_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic [DATA_W-1:0] wdata_o,
    output logic              ack_o
);
    logic pending;

    always_comb begin
        pending = wr_req_o || rd_req_o;
    end

    // Request register: issue when free, retire on done.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_req_o <= 1'b0;
            rd_req_o <= 1'b0;
            addr_o   <= '0;
            wdata_o  <= '0;
        end else if (pending) begin
            if (done_i) begin
                wr_req_o <= 1'b0;
                rd_req_o <= 1'b0;
            end
        end else if (cmd_valid_i) begin
            wr_req_o <= !cmd_rd_i;
            rd_req_o <= cmd_rd_i;
            addr_o   <= cmd_addr_i;
            wdata_o  <= cmd_rd_i ? '0 : cmd_data_i;
        end
    end

    // Completion strobe back to the sequencer.
    always_comb begin
        ack_o = pending && done_i;
    end

    // Read and write are never requested together.
    assert_one_req_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_req_o && rd_req_o));

    // A pending request keeps its address and data until done.
    assert_req_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (pending && !done_i) |=> (pending && $stable(addr_o) && $stable(wdata_o)
                                  && $stable(wr_req_o)));

    // A request drops at the edge after its done.
    assert_req_retire_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (pending && done_i) |=> !pending);

    // Input assumption: done only while a request is pending.
    assert_done_has_req_R4: assert property (@(posedge clk) disable iff (!rst_n)
        done_i |-> pending);

endmodule

// File: rtl/rfr_result_capture.sv
// Module: rfr_result_capture
// Holds the fault-present and link-down results taken from the status word.
// Clears on a new start and loads on the status read's completion.
// Assumes: clear_i and capture_i are never high together.
module rfr_result_capture #(
    parameter int DATA_W    = 16,
    parameter int FAULT_BIT = 4,
    parameter int LINK_BIT  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear_i,
    input  logic              capture_i,
    input  logic [DATA_W-1:0] rdata_i,
    output logic              fault_o,
    output logic              link_down_o
);
    // Result registers: clear on start, load on status read.
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i) begin
            fault_o     <= 1'b0;
            link_down_o <= 1'b0;
        end else if (capture_i) begin
            fault_o     <= rdata_i[FAULT_BIT];
            link_down_o <= !rdata_i[LINK_BIT];
        end
    end

    // Results change only on a capture or a clear.
    assert_results_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear_i && !capture_i) |=> ($stable(fault_o) && $stable(link_down_o)));

endmodule

// File: rtl/rfault_recheck_seq.sv
// Module: rfault_recheck_seq (top)
// Re-checks far-end fault status after a fault has been seen. The sequence is:
// write the loopback control word, wait WAIT_TICKS ticks, write the normal
// forced control word, then read status. It reports fault-present and
// link-down with a one-cycle done pulse.
// Assumes: start_i is pulsed only after a remote fault was observed; the
// register port obeys the done handshake described in rfr_access_port.
module rfault_recheck_seq #(
    parameter int              ADDR_W     = 5,
    parameter int              DATA_W     = 16,
    parameter int              WAIT_TICKS = 8,
    parameter logic [ADDR_W-1:0] CTRL_ADDR = 5'd0,
    parameter logic [ADDR_W-1:0] STAT_ADDR = 5'd1,
    parameter logic [DATA_W-1:0] LOOP_WORD = 16'h6100,
    parameter logic [DATA_W-1:0] NORM_WORD = 16'h2100,
    parameter int              FAULT_BIT  = 4,
    parameter int              LINK_BIT   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              tick_i,
    output logic              reg_wr_req_o,
    output logic              reg_rd_req_o,
    output logic [ADDR_W-1:0] reg_addr_o,
    output logic [DATA_W-1:0] reg_wdata_o,
    input  logic [DATA_W-1:0] reg_rdata_i,
    input  logic              reg_done_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              fault_present_o,
    output logic              link_down_o
);
    import rfr_pkg::*;

    rfr_state_e        state_q, state_d;
    logic              start_ok;
    logic              acc_ack;
    logic              wait_expired;
    logic              cmd_valid;
    logic              cmd_rd;
    logic [ADDR_W-1:0] cmd_addr;
    logic [DATA_W-1:0] cmd_data;

    // A start counts only while idle.
    always_comb begin
        start_ok = start_i && (state_q == ST_IDLE);
    end

    // Next-state logic of the recovery sequence.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (start_ok)     state_d = ST_LOOP_WR;
            ST_LOOP_WR: if (acc_ack)      state_d = ST_WAIT;
            ST_WAIT:    if (wait_expired) state_d = ST_NORM_WR;
            ST_NORM_WR: if (acc_ack)      state_d = ST_STAT_RD;
            ST_STAT_RD: if (acc_ack)      state_d = ST_REPORT;
            ST_REPORT:                    state_d = ST_IDLE;
            default:                      state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Command for the access port, chosen by the current step.
    always_comb begin
        cmd_valid = state_needs_access(state_q);
        cmd_rd    = (state_q == ST_STAT_RD);
        cmd_addr  = cmd_rd ? STAT_ADDR : CTRL_ADDR;
        cmd_data  = (state_q == ST_LOOP_WR) ? LOOP_WORD : NORM_WORD;
    end

    // Status flags derived from the state.
    always_comb begin
        busy_o = (state_q != ST_IDLE);
        done_o = (state_q == ST_REPORT);
    end

    rfr_access_port #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_access (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmd_valid_i (cmd_valid),
        .cmd_rd_i    (cmd_rd),
        .cmd_addr_i  (cmd_addr),
        .cmd_data_i  (cmd_data),
        .done_i      (reg_done_i),
        .wr_req_o    (reg_wr_req_o),
        .rd_req_o    (reg_rd_req_o),
        .addr_o      (reg_addr_o),
        .wdata_o     (reg_wdata_o),
        .ack_o       (acc_ack)
    );

    rfr_wait_timer #(
        .WAIT_TICKS (WAIT_TICKS)
    ) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_i     (state_q == ST_WAIT),
        .tick_i    (tick_i),
        .expired_o (wait_expired)
    );

    rfr_result_capture #(
        .DATA_W    (DATA_W),
        .FAULT_BIT (FAULT_BIT),
        .LINK_BIT  (LINK_BIT)
    ) u_result (
        .clk         (clk),
        .rst_n       (rst_n),
        .clear_i     (start_ok),
        .capture_i   (acc_ack && (state_q == ST_STAT_RD)),
        .rdata_i     (reg_rdata_i),
        .fault_o     (fault_present_o),
        .link_down_o (link_down_o)
    );

    // Done lasts a single cycle.
    assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // Reported results match the status word returned at the read's done.
    assert_result_map_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (fault_present_o == $past(reg_rdata_i[FAULT_BIT]))
                && (link_down_o == !$past(reg_rdata_i[LINK_BIT])));

    // A start while busy never launches a new loopback write.
    assert_busy_start_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i && !(reg_wr_req_o && reg_wdata_o == LOOP_WORD)
         && state_q != ST_LOOP_WR)
        |=> !(state_q == ST_LOOP_WR));

    // A write request carries one of the two control words to the control address.
    assert_write_target_R3: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr_req_o |-> (reg_addr_o == CTRL_ADDR)
                      && (reg_wdata_o == LOOP_WORD || reg_wdata_o == NORM_WORD));

    // The block leaves reset quiet.
    assert_reset_quiet_R8: assert property (@(posedge clk)
        !rst_n |=> (!reg_wr_req_o && !reg_rd_req_o && !busy_o && !done_o
                    && !fault_present_o && !link_down_o));

endmodule

// File: tb/test_rfault_recheck_seq.sv
module test_rfault_recheck_seq;

    localparam int WAIT_N = 8;

    typedef struct packed {
        logic        rd;
        logic [4:0]  addr;
        logic [15:0] data;
    } acc_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        tick_i = 1'b0;
    logic        reg_wr_req_o, reg_rd_req_o;
    logic [4:0]  reg_addr_o;
    logic [15:0] reg_wdata_o;
    logic [15:0] reg_rdata_i = 16'h0;
    logic        reg_done_i = 1'b0;
    logic        busy_o, done_o, fault_present_o, link_down_o;

    int n_cmp = 0;
    int n_bad = 0;
    int seq_seen = 0;
    int tick_div = 1;
    int resp_lat = 0;
    logic [15:0] stat_word = 16'h0;
    int tick_total = 0;
    int last_tick = 0;
    int tick_snap = 0;

    acc_t acc_q[$];
    logic [1:0] res_q[$];

    always #2 clk = ~clk;

    rfault_recheck_seq #(.WAIT_TICKS(WAIT_N)) i_rfault_recheck_seq (
        .clk             (clk),
        .rst_n           (rst_n),
        .start_i         (start_i),
        .tick_i          (tick_i),
        .reg_wr_req_o    (reg_wr_req_o),
        .reg_rd_req_o    (reg_rd_req_o),
        .reg_addr_o      (reg_addr_o),
        .reg_wdata_o     (reg_wdata_o),
        .reg_rdata_i     (reg_rdata_i),
        .reg_done_i      (reg_done_i),
        .busy_o          (busy_o),
        .done_o          (done_o),
        .fault_present_o (fault_present_o),
        .link_down_o     (link_down_o)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Tick source: one pulse every tick_div cycles.
    initial begin
        int c = 0;
        forever begin
            @(negedge clk);
            if (c >= tick_div - 1) begin
                tick_i = 1'b1;
                c = 0;
            end else begin
                tick_i = 1'b0;
                c++;
            end
        end
    end

    // Tick counter seen at rising edges.
    always @(posedge clk) begin
        last_tick  <= tick_i ? 1 : 0;
        tick_total <= tick_total + (tick_i ? 1 : 0);
    end

    // Register responder: checks each access against the expected queue.
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && (reg_wr_req_o || reg_rd_req_o)) begin
                acc_t got, exp;
                got = '{rd: reg_rd_req_o, addr: reg_addr_o, data: reg_rd_req_o ? 16'h0 : reg_wdata_o};
                if (acc_q.size() == 0) begin
                    check(1'b0, "R7 unexpected access", 32'(got), 32'h0);
                    exp = got;
                end else begin
                    exp = acc_q.pop_front();
                    check(got == exp, "R1/R3/R4 access order (R1 R3 R4)", 32'(got), 32'(exp));
                end
                if (!got.rd && got.data == 16'h2100) begin
                    check((tick_total - last_tick - tick_snap) == WAIT_N, "R2 tick wait",
                          32'(tick_total - last_tick - tick_snap), 32'(WAIT_N));
                end
                repeat (resp_lat) @(negedge clk);
                reg_rdata_i = got.rd ? stat_word : 16'hxxxx;
                reg_done_i  = 1'b1;
                @(negedge clk);
                reg_done_i  = 1'b0;
                reg_rdata_i = 16'h0;
                if (!got.rd && got.data == 16'h6100) tick_snap = tick_total;
            end
        end
    end

    // Monitor: compares results on each done pulse and checks it is one cycle.
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && done_o) begin
                logic [1:0] exp;
                if (res_q.size() == 0) begin
                    check(1'b0, "R6 unexpected done", 32'h1, 32'h0);
                    exp = 2'b00;
                end else begin
                    exp = res_q.pop_front();
                end
                check({fault_present_o, link_down_o} == exp, "R5 results",
                      {fault_present_o, link_down_o}, exp);
                @(negedge clk);
                check(!done_o, "R6 done single cycle", done_o, 0);
                check(!busy_o, "R6 idle after done", busy_o, 0);
                seq_seen++;
            end
        end
    end

    task automatic run_seq(input logic [15:0] stat, input int lat, input int tdiv,
                           input bit poke_busy);
        int target;
        logic [1:0] r;
        target    = seq_seen + 1;
        stat_word = stat;
        resp_lat  = lat;
        tick_div  = tdiv;
        acc_q.push_back('{rd: 1'b0, addr: 5'd0, data: 16'h6100});
        acc_q.push_back('{rd: 1'b0, addr: 5'd0, data: 16'h2100});
        acc_q.push_back('{rd: 1'b1, addr: 5'd1, data: 16'h0});
        res_q.push_back({stat[4], !stat[2]});
        @(negedge clk);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        check(busy_o, "R1 busy after start", busy_o, 1);
        check(!fault_present_o && !link_down_o, "R6 results cleared on start",
              {fault_present_o, link_down_o}, 0);
        if (poke_busy) begin
            repeat (3) @(negedge clk);
            start_i = 1'b1;
            @(negedge clk);
            start_i = 1'b0;
            check(busy_o, "R7 busy kept", busy_o, 1);
        end
        while (seq_seen < target) @(negedge clk);
        r = {stat[4], !stat[2]};
        repeat (12) @(negedge clk);
        check({fault_present_o, link_down_o} == r, "R6 results held",
              {fault_present_o, link_down_o}, r);
        check(!busy_o && !reg_wr_req_o && !reg_rd_req_o, "R7 no extra activity",
              {busy_o, reg_wr_req_o, reg_rd_req_o}, 0);
    endtask

    initial begin
        fork
            begin
                repeat (3) @(negedge clk);
                check(!reg_wr_req_o && !reg_rd_req_o && !busy_o && !done_o, "R8 in reset",
                      {reg_wr_req_o, reg_rd_req_o, busy_o, done_o}, 0);
                rst_n = 1'b1;
                @(negedge clk);
                check(!busy_o && !fault_present_o && !link_down_o, "R8 after reset",
                      {busy_o, fault_present_o, link_down_o}, 0);
                run_seq(16'h0010, 0, 1, 1'b0);
                run_seq(16'h0004, 3, 3, 1'b0);
                run_seq(16'h0014, 1, 2, 1'b1);
                run_seq(16'h0000, 2, 1, 1'b1);
                run_seq(16'hFFEB, 0, 4, 1'b0);
                check(acc_q.size() == 0, "R4 all accesses seen", acc_q.size(), 0);
            end
            begin
                repeat (100000) @(posedge clk);
                check(1'b0, "watchdog R1", 0, 1);
            end
        join_any
        disable fork;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule